// File: doc/BRIEF.md
# Mode-Banked Register File

This block is the general-purpose register store of a 32-bit processor core. It has sixteen logical registers, R0 to R15. The current processor mode decides which of 31 physical registers each logical index reaches. Two combinational read ports and one clocked write port take 4-bit logical indices. A 5-bit mode input steers the logical-to-physical mapping for all three ports at once.

Each exception mode has its own stack pointer (R13) and link register (R14). The fast-interrupt mode also has its own R8 to R12, so a handler in that mode can start without saving those registers. System mode and User mode share every register.

R15 is the program counter and is not held in the general storage. It has its own advance path, and a write to index 15 loads it directly. A read of R15 returns the current instruction address plus a fixed read-ahead offset. A second write port sets the link register of the mode being entered, in the same cycle as an exception is taken.

Top module: `rf_banked_regfile`

## Requirements
- R1: After reset every general register reads 0 in every mode, the program counter output is 0, and a read of index 15 returns 8.
- R2: Each read port returns the register that its index and the current mode select, combinationally, with no clock edge needed.
- R3: A write through the write port takes effect at the next rising clock edge. A read of the same register in the write cycle returns the old value, and from the next cycle it returns the new value.
- R4: System mode (5'b11111) and User mode (5'b10000) reach the same physical register for every index. Any mode value that is not one of the seven listed encodings behaves as User mode.
- R5: Fast-interrupt mode (5'b10001) has private R8, R9, R10, R11, R12, R13 and R14. A write to any of these is not seen from any other mode, and writes from other modes to these indices are not seen in fast-interrupt mode.
- R6: Normal-interrupt (5'b10010), supervisor (5'b10011), abort (5'b10111) and undefined (5'b11011) modes each have a private R13 and R14. R0 to R12 are shared with User mode.
- R7: A read of index 15 on either port returns the program counter plus 8.
- R8: While the advance input is high, the program counter grows by 4 at each clock edge. While it is low and there is no load, the program counter holds its value.
- R9: A write to index 15 loads the program counter with the write data at the next edge. The load wins over a simultaneous advance.
- R10: The exception-link port writes R14 of the mode given on its own target-mode input, whatever the current mode. If it hits the same physical register as the normal write port in the same cycle, the exception-link data wins.
- R11: An exception-link write whose target mode is User, System or an unlisted encoding updates the User R14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cur_mode | input | 5 | Current processor mode; selects the bank for all ports |
| rd_a_idx | input | 4 | Logical index, read port A |
| rd_a_data | output | 32 | Read data, port A |
| rd_b_idx | input | 4 | Logical index, read port B |
| rd_b_data | output | 32 | Read data, port B |
| wr_en | input | 1 | Write enable, normal write port |
| wr_idx | input | 4 | Logical index, normal write port (15 loads the program counter) |
| wr_data | input | 32 | Write data, normal write port |
| pc_adv | input | 1 | Advance the program counter by 4 |
| pc_o | output | 32 | Current instruction address |
| exc_en | input | 1 | Exception-link write enable |
| exc_mode | input | 5 | Mode being entered; its R14 is written |
| exc_lr | input | 32 | Return address written by the exception-link port |

## Verification
The in-RTL assertions check, on every cycle, how the program counter steps, holds and loads. They also check that each write commits one cycle later, that an exception-link write lands, and that the physical index stays in range, with low registers shared and the fast-interrupt R8 to R12 kept in their own bank. Only the bench scenarios can show that a value written in one mode stays hidden from or visible to another mode. The same goes for read-before-write ordering within a cycle, the offset seen on an R15 read, and the result when both write ports collide.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;
  localparam int DATA_W        = 32;
  localparam int LOG_IDX_W     = 4;
  localparam int MODE_W        = 5;
  localparam int LOW_SHARED    = 15;  // R0..R14 of the user/system bank
  localparam int FIQ_PRIV      = 5;   // fast-interrupt R8..R12
  localparam int NUM_EXC_MODES = 5;
  localparam int FIQ_BASE      = LOW_SHARED;
  localparam int EXC_BASE      = FIQ_BASE + FIQ_PRIV;
  localparam int NUM_GPR       = EXC_BASE + 2 * NUM_EXC_MODES;
  localparam int PHYS_AW       = $clog2(NUM_GPR);
  localparam int FIQ_LO_IDX    = 8;
  localparam int FIQ_HI_IDX    = 12;
  localparam int SP_IDX        = 13;
  localparam int LR_IDX        = 14;
  localparam int PC_IDX        = 15;

  localparam logic [MODE_W-1:0] MODE_USR = 5'b10000;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] MODE_UND = 5'b11011;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'b11111;

  // Bank order fixes the position of each exception pair above EXC_BASE.
  typedef enum logic [2:0] {
    BANK_USR = 3'd0,
    BANK_FIQ = 3'd1,
    BANK_IRQ = 3'd2,
    BANK_SVC = 3'd3,
    BANK_ABT = 3'd4,
    BANK_UND = 3'd5
  } bank_e;
endpackage

// File: rtl/rf_mode_decode.sv
`timescale 1ns/1ps
module rf_mode_decode
  import rf_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output bank_e             bank_o
);
  always_comb begin
    unique case (mode_i)
      MODE_FIQ: bank_o = BANK_FIQ;
      MODE_IRQ: bank_o = BANK_IRQ;
      MODE_SVC: bank_o = BANK_SVC;
      MODE_ABT: bank_o = BANK_ABT;
      MODE_UND: bank_o = BANK_UND;
      default:  bank_o = BANK_USR;  // user, system and unlisted codes
    endcase
  end
endmodule

// File: rtl/rf_phys_map.sv
`timescale 1ns/1ps
module rf_phys_map
  import rf_pkg::*;
(
  input  logic [LOG_IDX_W-1:0] idx_i,
  input  bank_e                bank_i,
  output logic [PHYS_AW-1:0]   phys_o,
  output logic                 is_pc_o
);
  int unsigned idx_int;
  int unsigned bank_int;

  always_comb begin
    idx_int  = int'(idx_i);
    bank_int = int'(bank_i);
    is_pc_o  = (idx_int == PC_IDX);
    phys_o   = PHYS_AW'(idx_int);
    if (is_pc_o) begin
      phys_o = '0;
    end else if (bank_i == BANK_FIQ && idx_int >= FIQ_LO_IDX && idx_int <= FIQ_HI_IDX) begin
      phys_o = PHYS_AW'(FIQ_BASE + idx_int - FIQ_LO_IDX);
    end else if (bank_i != BANK_USR && idx_int >= SP_IDX) begin
      phys_o = PHYS_AW'(EXC_BASE + 2 * (bank_int - 1) + idx_int - SP_IDX);
    end
  end
endmodule

// File: rtl/rf_storage.sv
`timescale 1ns/1ps
module rf_storage #(
  parameter int DW   = 32,
  parameter int NREG = 30,
  parameter int AW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_a,
  input  logic [AW-1:0] addr_a,
  input  logic [DW-1:0] data_a,
  input  logic          we_b,     // wins over port a on the same address
  input  logic [AW-1:0] addr_b,
  input  logic [DW-1:0] data_b,
  output logic [DW-1:0] regs_o [NREG]
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic          en;
    logic [DW-1:0] d;
    logic [DW-1:0] q;

    always_comb begin
      en = 1'b0;
      d  = data_a;
      if (we_b && addr_b == AW'(g)) begin
        en = 1'b1;
        d  = data_b;
      end else if (we_a && addr_a == AW'(g)) begin
        en = 1'b1;
        d  = data_a;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign regs_o[g] = q;
  end
endmodule

// File: rtl/rf_pc_unit.sv
`timescale 1ns/1ps
module rf_pc_unit #(
  parameter int          DW       = 32,
  parameter logic [31:0] STEP     = 32'd4,
  parameter logic [31:0] RESET_PC = 32'd0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv_i,
  input  logic          ld_i,
  input  logic [DW-1:0] ld_val_i,
  output logic [DW-1:0] pc_o
);
  logic [DW-1:0] pc_q, pc_d;
  logic          pc_en;

  always_comb begin
    pc_en = ld_i | adv_i;
    pc_d  = pc_q;
    if (ld_i)       pc_d = ld_val_i;
    else if (adv_i) pc_d = pc_q + DW'(STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= DW'(RESET_PC);
    else if (pc_en) pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  assert_pc_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !ld_i) |=> pc_q == $past(pc_q) + DW'(STEP));
  assert_pc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !ld_i) |=> $stable(pc_q));
  assert_pc_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> pc_q == $past(ld_val_i));
endmodule

// File: rtl/rf_banked_regfile.sv
`timescale 1ns/1ps
module rf_banked_regfile
  import rf_pkg::*;
#(
  parameter logic [31:0] PC_STEP    = 32'd4,
  parameter logic [31:0] PC_READ_OFS = 32'd8,
  parameter logic [31:0] RESET_PC   = 32'd0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [MODE_W-1:0]    cur_mode,
  input  logic [LOG_IDX_W-1:0] rd_a_idx,
  output logic [DATA_W-1:0]    rd_a_data,
  input  logic [LOG_IDX_W-1:0] rd_b_idx,
  output logic [DATA_W-1:0]    rd_b_data,
  input  logic                 wr_en,
  input  logic [LOG_IDX_W-1:0] wr_idx,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 pc_adv,
  output logic [DATA_W-1:0]    pc_o,
  input  logic                 exc_en,
  input  logic [MODE_W-1:0]    exc_mode,
  input  logic [DATA_W-1:0]    exc_lr
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  bank_e cur_bank, exc_bank;
  rf_mode_decode i_dec_cur (.mode_i(cur_mode), .bank_o(cur_bank));
  rf_mode_decode i_dec_exc (.mode_i(exc_mode), .bank_o(exc_bank));

  logic [PHYS_AW-1:0] a_phys, b_phys, w_phys, x_phys;
  logic               a_is_pc, b_is_pc, w_is_pc, x_is_pc;

  rf_phys_map i_map_a (.idx_i(rd_a_idx), .bank_i(cur_bank), .phys_o(a_phys), .is_pc_o(a_is_pc));
  rf_phys_map i_map_b (.idx_i(rd_b_idx), .bank_i(cur_bank), .phys_o(b_phys), .is_pc_o(b_is_pc));
  rf_phys_map i_map_w (.idx_i(wr_idx),   .bank_i(cur_bank), .phys_o(w_phys), .is_pc_o(w_is_pc));
  rf_phys_map i_map_x (.idx_i(LOG_IDX_W'(LR_IDX)), .bank_i(exc_bank),
                       .phys_o(x_phys), .is_pc_o(x_is_pc));

  logic gpr_we, pc_ld;
  always_comb begin
    gpr_we = wr_en & ~w_is_pc;
    pc_ld  = wr_en &  w_is_pc;
  end

  logic [DATA_W-1:0] regs [NUM_GPR];
  rf_storage #(.DW(DATA_W), .NREG(NUM_GPR), .AW(PHYS_AW)) i_store (
    .clk   (clk),
    .rst_n (rst_core_n),
    .we_a  (gpr_we),
    .addr_a(w_phys),
    .data_a(wr_data),
    .we_b  (exc_en & ~x_is_pc),
    .addr_b(x_phys),
    .data_b(exc_lr),
    .regs_o(regs)
  );

  logic [DATA_W-1:0] pc_q;
  rf_pc_unit #(.DW(DATA_W), .STEP(PC_STEP), .RESET_PC(RESET_PC)) i_pc (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .adv_i   (pc_adv),
    .ld_i    (pc_ld),
    .ld_val_i(wr_data),
    .pc_o    (pc_q)
  );

  logic [DATA_W-1:0] pc_read;
  always_comb begin
    pc_read   = pc_q + DATA_W'(PC_READ_OFS);
    rd_a_data = a_is_pc ? pc_read : regs[a_phys];
    rd_b_data = b_is_pc ? pc_read : regs[b_phys];
    pc_o      = pc_q;
  end

  // Assertions
  assert_phys_range_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    !a_is_pc |-> int'(a_phys) < NUM_GPR);
  assert_low_shared_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (int'(rd_a_idx) < FIQ_LO_IDX) |-> a_phys == PHYS_AW'(rd_a_idx));
  assert_fiq_private_R5: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cur_mode == MODE_FIQ && int'(rd_a_idx) >= FIQ_LO_IDX && int'(rd_a_idx) <= LR_IDX)
      |-> (int'(a_phys) >= FIQ_BASE));
  assert_sys_user_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    ((cur_mode == MODE_SYS || cur_mode == MODE_USR) && !a_is_pc)
      |-> a_phys == PHYS_AW'(rd_a_idx));
  assert_write_commit_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    (gpr_we && !(exc_en && x_phys == w_phys)) |=> regs[$past(w_phys)] == $past(wr_data));
  assert_exc_link_R10: assert property (@(posedge clk) disable iff (!rst_core_n)
    exc_en |=> regs[$past(x_phys)] == $past(exc_lr));
endmodule

// File: tb/test_rf_banked_regfile.sv
`timescale 1ns/1ps
module test_rf_banked_regfile;
  localparam logic [4:0] USR = 5'b10000, FIQ = 5'b10001, IRQ = 5'b10010,
                         SVC = 5'b10011, ABT = 5'b10111, UND = 5'b11011,
                         SYS = 5'b11111, BAD = 5'b00000;

  logic        clk, rst_n;
  logic [4:0]  cur_mode, exc_mode;
  logic [3:0]  rd_a_idx, rd_b_idx, wr_idx;
  logic [31:0] rd_a_data, rd_b_data, wr_data, pc_o, exc_lr;
  logic        wr_en, pc_adv, exc_en;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  rf_banked_regfile i_rf_banked_regfile (
    .clk(clk), .rst_n(rst_n), .cur_mode(cur_mode),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pc_adv(pc_adv), .pc_o(pc_o),
    .exc_en(exc_en), .exc_mode(exc_mode), .exc_lr(exc_lr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // {write mode, write idx, write data, read mode, read idx, expected}
  localparam int NV = 12;
  localparam logic [81:0] VEC [NV] = '{
    {USR, 4'd3,  32'h11, USR, 4'd3,  32'h11},  // R2 R3 basic
    {FIQ, 4'd8,  32'h22, USR, 4'd8,  32'h00},  // R5 fiq write hidden
    {USR, 4'd8,  32'h33, FIQ, 4'd8,  32'h22},  // R5 user write hidden
    {IRQ, 4'd13, 32'h44, SVC, 4'd13, 32'h00},  // R6
    {SVC, 4'd13, 32'h55, IRQ, 4'd13, 32'h44},  // R6
    {ABT, 4'd14, 32'h66, UND, 4'd14, 32'h00},  // R6
    {SYS, 4'd13, 32'h77, USR, 4'd13, 32'h77},  // R4
    {BAD, 4'd14, 32'h88, SYS, 4'd14, 32'h88},  // R4 unlisted code
    {IRQ, 4'd12, 32'h99, FIQ, 4'd12, 32'h00},  // R5
    {UND, 4'd0,  32'hAA, USR, 4'd12, 32'h99},  // R6 shared low regs
    {FIQ, 4'd14, 32'hBB, ABT, 4'd14, 32'h66},  // R5 R6
    {USR, 4'd1,  32'hCC, USR, 4'd3,  32'h11}   // R3 no disturbance
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cur_mode = USR; exc_mode = USR; rd_a_idx = 0; rd_b_idx = 0;
    wr_en = 0; wr_idx = 0; wr_data = 0; pc_adv = 0; exc_en = 0; exc_lr = 0;
    repeat (3) tick();
    rst_n = 1;
    repeat (3) tick();

    // R1 reset state
    chk("R1 pc_o", pc_o, 32'h0);
    for (int m = 0; m < 2; m++) begin
      cur_mode = (m == 0) ? USR : FIQ;
      for (int i = 0; i < 15; i++) begin
        rd_a_idx = 4'(i); #1;
        chk("R1 reg", rd_a_data, 32'h0);
      end
    end
    cur_mode = USR; rd_b_idx = 4'd15; #1;
    chk("R1 R7 pc read", rd_b_data, 32'h8);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      cur_mode = VEC[v][81:77]; wr_idx = VEC[v][76:73]; wr_data = VEC[v][72:41];
      wr_en = 1;
      tick();
      wr_en = 0;
      cur_mode = VEC[v][40:36]; rd_a_idx = VEC[v][35:32]; rd_b_idx = VEC[v][35:32];
      #1;
      chk("R2 R4 R5 R6 vec port a", rd_a_data, VEC[v][31:0]);
      chk("R2 vec port b", rd_b_data, VEC[v][31:0]);
    end

    // R3 read-before-write in the same cycle
    cur_mode = USR; rd_a_idx = 4'd5; wr_idx = 4'd5; wr_data = 32'h1234; wr_en = 1; #1;
    chk("R3 old value", rd_a_data, 32'h0);
    tick();
    wr_en = 0; #1;
    chk("R3 new value", rd_a_data, 32'h1234);

    // R8 advance and hold
    pc_adv = 1;
    repeat (3) tick();
    chk("R8 advance", pc_o, 32'd12);
    rd_a_idx = 4'd15; #1;
    chk("R7 pc read a", rd_a_data, 32'd20);
    pc_adv = 0;
    tick();
    chk("R8 hold", pc_o, 32'd12);

    // R9 load wins over advance
    pc_adv = 1; wr_en = 1; wr_idx = 4'd15; wr_data = 32'h100;
    tick();
    wr_en = 0; pc_adv = 0; rd_b_idx = 4'd15; #1;
    chk("R9 load", pc_o, 32'h100);
    chk("R7 R9 pc read b", rd_b_data, 32'h108);

    // R10 link to target mode, alongside a user write of R14
    cur_mode = USR; exc_en = 1; exc_mode = SVC; exc_lr = 32'h500;
    wr_en = 1; wr_idx = 4'd14; wr_data = 32'h600;
    tick();
    exc_en = 0; wr_en = 0; rd_a_idx = 4'd14; #1;
    chk("R10 user lr", rd_a_data, 32'h600);
    cur_mode = SVC; #1;
    chk("R10 svc lr", rd_a_data, 32'h500);

    // R10 collision: link port wins
    cur_mode = SVC; exc_en = 1; exc_mode = SVC; exc_lr = 32'h800;
    wr_en = 1; wr_idx = 4'd14; wr_data = 32'h700;
    tick();
    exc_en = 0; wr_en = 0; #1;
    chk("R10 collision", rd_a_data, 32'h800);

    // R11 unlisted target mode writes user R14
    cur_mode = FIQ; exc_en = 1; exc_mode = 5'b00101; exc_lr = 32'h900;
    tick();
    exc_en = 0; #1;
    chk("R11 fiq lr untouched", rd_a_data, 32'hBB);
    cur_mode = USR; #1;
    chk("R11 user lr", rd_a_data, 32'h900);

    // R5 link into fast-interrupt bank
    exc_en = 1; exc_mode = FIQ; exc_lr = 32'hA00;
    tick();
    exc_en = 0; cur_mode = FIQ; #1;
    chk("R5 R10 fiq lr", rd_a_data, 32'hA00);

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule